// File: doc/BRIEF.md
# Floating-Point Input Operand Screen

This block looks at a 64-bit double-precision register operand before an arithmetic instruction consumes it. It decides whether the operand must be sent to a trap handler, and it returns the code bits that go with that trap. It splits the operand into an 11-bit exponent (bits 62:52) and a 52-bit fraction (bits 51:0). It then applies one of three screening policies, chosen per instruction class. Plain arithmetic rejects every non-finite value and every denormal. Comparison lets infinities through but still rejects NaNs and denormals. Software-completion screens only denormals, and flush-inputs-to-zero can waive that check.

The decision is fully combinational. A sticky-invalid set pulse tells the floating-point control register to record an invalid operation. The control register, trap delivery and the arithmetic datapath all sit outside this block. A registered copy of the four result bits is also provided. It loads one cycle after a valid strobe and holds its value until the next strobe.

Top module: `fp_operand_screen`

## Requirements
- R1: The operand sign (bit 63) never changes any output. The exponent is bits 62:52 and the fraction is bits 51:0.
- R2: With mode = 0 (plain), an all-zero exponent with a nonzero fraction raises trap_c and inv_c with sticky_c low.
- R3: With mode = 0, an all-ones exponent (infinity or NaN) raises trap_c, inv_c and sticky_c together.
- R4: With mode = 1 (comparison), an infinity (all-ones exponent, zero fraction) raises nothing. A NaN raises trap_c, inv_c and sticky_c. A denormal raises trap_c and inv_c with sticky_c low.
- R5: With mode = 2 (software completion) and flush_in low, a denormal raises trap_c, inv_c and swc_c with sticky_c low. Infinities and NaNs raise nothing in this mode.
- R6: With mode = 2, flush_in high suppresses the denormal trap. In modes 0 and 1, flush_in has no effect.
- R7: A zero of either sign, or any operand whose exponent is neither all-zero nor all-ones, raises no output in any mode.
- R8: swc_c is asserted only in mode 2, and only together with trap_c.
- R9: mode = 3 is reserved, and every combinational output stays low in that mode.
- R10: All four registered outputs are 0 after reset. On a clock edge where in_valid is high, they take the combinational results of that cycle. While in_valid is low, they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered copy |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe that loads the registered outputs |
| operand | input | 64 | Double-precision operand under test |
| mode | input | 2 | 0 plain, 1 comparison, 2 software completion, 3 reserved |
| flush_in | input | 1 | Flush-inputs-to-zero control |
| trap_c | output | 1 | Trap request (combinational) |
| inv_c | output | 1 | Invalid-operation code bit (combinational) |
| swc_c | output | 1 | Software-completion code bit (combinational) |
| sticky_c | output | 1 | Sticky invalid-flag set pulse (combinational) |
| trap_q | output | 1 | Registered trap request |
| inv_q | output | 1 | Registered invalid code bit |
| swc_q | output | 1 | Registered software-completion bit |
| sticky_q | output | 1 | Registered sticky set pulse |

## Verification
The bench targets the points where the three policies disagree:
- An infinity in comparison mode: a design that treats it like plain mode would trap there.
- A denormal: a design that sets the sticky bit for it would log a spurious invalid flag.
- Negative zero in software-completion mode: a sign-sensitive design would trap on it.
- The largest and smallest denormals, and the smallest normal, to catch an off-by-one in the software-completion range test.
- flush_in in plain and comparison modes, where a leak would wrongly suppress traps.

Strobe-free cycles check that the registered copy holds its value and does not follow the live inputs.

// File: rtl/fp_screen_pkg.sv
package fp_screen_pkg;
  localparam int OPND_W = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int EXP_LSB = FRAC_W;
  localparam int SIGN_BIT = OPND_W - 1;

  typedef enum logic [1:0] {
    SCR_PLAIN = 2'd0,
    SCR_CMP   = 2'd1,
    SCR_SWC   = 2'd2,
    SCR_RSVD  = 2'd3
  } scr_mode_e;

  typedef struct packed {
    logic exp_zero;
    logic exp_ones;
    logic frac_nz;
    logic swc_denorm;
  } opnd_flags_t;

  typedef struct packed {
    logic trap;
    logic inv;
    logic swc;
    logic sticky;
  } scr_result_t;

  // Software-completion denormal test done arithmetically: doubling drops
  // the sign, and subtracting one makes zero wrap to all ones so it passes.
  function automatic logic swc_denorm_test(input logic [OPND_W-1:0] v);
    logic [OPND_W-1:0] t;
    logic [OPND_W-1:0] lim;
    t   = {v[OPND_W-2:0], 1'b0} - {{(OPND_W-1){1'b0}}, 1'b1};
    lim = ({{(OPND_W-1){1'b0}}, 1'b1} << (FRAC_W + 1)) - {{(OPND_W-1){1'b0}}, 1'b1};
    return t < lim;
  endfunction
endpackage

// File: rtl/scr_fields.sv
module scr_fields
  import fp_screen_pkg::*;
(
  input  logic [OPND_W-1:0] operand,
  output opnd_flags_t       flags
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = operand[EXP_LSB +: EXP_W];
  assign frac_f = operand[FRAC_W-1:0];

  assign flags.exp_zero   = (exp_f == '0);
  assign flags.exp_ones   = (exp_f == '1);
  assign flags.frac_nz    = (frac_f != '0);
  assign flags.swc_denorm = swc_denorm_test(operand);
endmodule

// File: rtl/scr_policy.sv
module scr_policy
  import fp_screen_pkg::*;
(
  input  opnd_flags_t flags,
  input  logic [1:0]  mode,
  input  logic        flush_in,
  output scr_result_t res
);
  logic is_denorm;
  logic is_nan;

  assign is_denorm = flags.exp_zero & flags.frac_nz;
  assign is_nan    = flags.exp_ones & flags.frac_nz;

  always_comb begin
    res = '0;
    unique case (scr_mode_e'(mode))
      SCR_PLAIN: begin
        res.trap   = is_denorm | flags.exp_ones;
        res.inv    = is_denorm | flags.exp_ones;
        res.sticky = flags.exp_ones;
      end
      SCR_CMP: begin
        res.trap   = is_denorm | is_nan;
        res.inv    = is_denorm | is_nan;
        res.sticky = is_nan;
      end
      SCR_SWC: begin
        res.trap = flags.swc_denorm & ~flush_in;
        res.inv  = flags.swc_denorm & ~flush_in;
        res.swc  = flags.swc_denorm & ~flush_in;
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/scr_hold.sv
module scr_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/fp_operand_screen.sv
module fp_operand_screen
  import fp_screen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] operand,
  input  logic [1:0]  mode,
  input  logic        flush_in,
  output logic        trap_c,
  output logic        inv_c,
  output logic        swc_c,
  output logic        sticky_c,
  output logic        trap_q,
  output logic        inv_q,
  output logic        swc_q,
  output logic        sticky_q
);
  localparam int RES_W = $bits(scr_result_t);

  opnd_flags_t flags;
  scr_result_t res_c;
  scr_result_t res_q;

  scr_fields u_fields (
    .operand (operand),
    .flags   (flags)
  );

  scr_policy u_policy (
    .flags    (flags),
    .mode     (mode),
    .flush_in (flush_in),
    .res      (res_c)
  );

  scr_hold #(.W(RES_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid),
    .d     (res_c),
    .q     (res_q)
  );

  assign trap_c   = res_c.trap;
  assign inv_c    = res_c.inv;
  assign swc_c    = res_c.swc;
  assign sticky_c = res_c.sticky;
  assign trap_q   = res_q.trap;
  assign inv_q    = res_q.inv;
  assign swc_q    = res_q.swc;
  assign sticky_q = res_q.sticky;
endmodule

// File: rtl/fp_operand_screen_chk.sv
module fp_operand_screen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] operand,
  input logic [1:0]  mode,
  input logic        flush_in,
  input logic        trap_c,
  input logic        inv_c,
  input logic        swc_c,
  input logic        sticky_c,
  input logic        trap_q,
  input logic        inv_q,
  input logic        swc_q,
  input logic        sticky_q
);
  logic normal_or_zero;
  assign normal_or_zero = (operand[62:0] == 63'd0) ||
                          (operand[62:52] != 11'h000 && operand[62:52] != 11'h7FF);

  // R7
  finite_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    normal_or_zero |-> !trap_c && !sticky_c);

  // R8
  swc_only_mode2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swc_c |-> (mode == 2'd2) && trap_c);

  // R9
  rsvd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> !trap_c && !inv_c && !swc_c && !sticky_c);

  // R5
  swc_no_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> !sticky_c);

  // R3
  sticky_with_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_c |-> trap_c && inv_c);

  // R6
  flush_swc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && flush_in) |-> !trap_c);

  // R10
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> {trap_q, inv_q, swc_q, sticky_q} ==
                 $past({trap_c, inv_c, swc_c, sticky_c}));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({trap_q, inv_q, swc_q, sticky_q}));
endmodule

bind fp_operand_screen fp_operand_screen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
  .mode(mode), .flush_in(flush_in), .trap_c(trap_c), .inv_c(inv_c),
  .swc_c(swc_c), .sticky_c(sticky_c), .trap_q(trap_q), .inv_q(inv_q),
  .swc_q(swc_q), .sticky_q(sticky_q)
);

// File: tb/fp_operand_screen_tb.sv
module fp_operand_screen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [63:0] operand = '0;
  logic [1:0]  mode = '0;
  logic        flush_in = 0;
  logic trap_c, inv_c, swc_c, sticky_c, trap_q, inv_q, swc_q, sticky_q;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [3:0] q_model = 4'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_operand_screen u_dut (.*);

  // Reference: {trap, inv, swc, sticky} decided from the field classes.
  function automatic logic [3:0] ref_model(input logic [63:0] op, input int m, input bit fl);
    int e = int'(op[62:52]);
    bit fz = (op[51:0] == 52'd0);
    bit den = (e == 0) && !fz;
    bit inf = (e == 2047) && fz;
    bit nan = (e == 2047) && !fz;
    if (m == 0) begin
      if (inf || nan) return 4'b1101;
      if (den)        return 4'b1100;
    end else if (m == 1) begin
      if (nan) return 4'b1101;
      if (den) return 4'b1100;
    end else if (m == 2) begin
      if (den && !fl) return 4'b1110;
    end
    return 4'b0000;
  endfunction

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%b expected=%b (op=%h mode=%0d flush=%0b)",
               tag, what, act, exp, operand, mode, flush_in);
    end
  endtask

  task automatic apply(input logic [63:0] op, input int m, input bit fl, input bit v, input string tag);
    logic [3:0] e;
    @(negedge clk);
    operand = op; mode = 2'(m); flush_in = fl; in_valid = v;
    #1;
    e = ref_model(op, m, fl);
    check({trap_c, inv_c, swc_c, sticky_c}, e, tag, "comb");
    if (v) q_model = e;
    @(posedge clk);
    #1;
    check({trap_q, inv_q, swc_q, sticky_q}, q_model, "R10", "reg");
  endtask

  localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] DMIN  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] DMAX  = 64'h000F_FFFF_FFFF_FFFF;
  localparam logic [63:0] NMIN  = 64'h0010_0000_0000_0000;
  localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({trap_q, inv_q, swc_q, sticky_q}, 4'b0000, "R10", "reset");
    @(negedge clk);
    rst_n = 1;

    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 2; f++) begin
        apply(PZERO, m, f[0], 1, "R7");
        apply(NZERO, m, f[0], 1, "R7");
        apply(NMIN,  m, f[0], 1, "R7");
        apply(ONE,   m, f[0], 1, "R7");
        apply(DMIN,  m, f[0], 1, m == 2 ? "R6" : "R2");
        apply(DMAX | 64'h8000_0000_0000_0000, m, f[0], 1, "R1");
        apply(PINF,  m, f[0], 1, m == 1 ? "R4" : "R3");
        apply(NINF,  m, f[0], 1, m == 2 ? "R5" : "R4");
        apply(QNAN,  m, f[0], 1, m == 3 ? "R9" : "R3");
        apply(SNAN,  m, f[0], 1, m == 2 ? "R8" : "R4");
      end
    end

    // R10: hold while strobe is low, live inputs change underneath
    apply(PINF, 0, 0, 1, "R3");
    apply(ONE,  0, 0, 0, "R10");
    apply(DMIN, 2, 0, 0, "R10");
    apply(DMIN, 2, 0, 1, "R5");
    apply(QNAN, 1, 0, 0, "R10");

    // R1 and mixed patterns: biased exponent choice
    for (int i = 0; i < 2000; i++) begin
      logic [63:0] op;
      int sel;
      op = {$urandom, $urandom};
      sel = int'($urandom % 4);
      if (sel == 0) op[62:52] = 11'h000;
      else if (sel == 1) op[62:52] = 11'h7FF;
      if (($urandom % 8) == 0) op[51:0] = '0;
      apply(op, int'($urandom % 4), 1'($urandom), 1'($urandom), "R1");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule